// File: doc/BRIEF.md
# Calorimeter trigger primitive encoder

The encoder serves two calorimeter towers on every bunch-crossing clock. Each tower arrives as two linear energies, one for each depth segment. The block adds the two depths of a tower and clamps the sum to the range of a loadable energy table. The table turns that index into an 8-bit compressed transverse-energy code. A separate test on the unclamped sum raises a muon feature bit when the tower deposit falls inside a window around the energy of one minimum-ionizing particle.

Both towers, an abort-gap flag and a 5-bit single-error-correcting check field leave as one 24-bit word per crossing. The pipeline never stalls. A word leaves exactly three clocks after its inputs are sampled.

The energy table is filled through a plain address/data/write port. That port is honoured only while no sample is in flight.

Top module: `tpe_encoder`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one cycle with `out_valid` high, three rising edges later. `out_valid` is high in no other cycle, and back-to-back samples are accepted without stall.
- R2: For each tower the two depth energies are added at full width. The table index is that sum, clamped to 255 when the sum exceeds 255, so large inputs never wrap.
- R3: The compressed energy of a tower is the table entry at its index. Tower A's code goes to `out_word[7:0]` and tower B's code to `out_word[16:9]`.
- R4: A tower's muon bit is 1 exactly when its unclamped depth sum lies in `MIP_LO`..`MIP_HI` inclusive (default 6..10, with a 0.25 GeV input LSB, so about 1.5 to 2.5 GeV). The bit goes to `out_word[8]` for tower A and `out_word[17]` for tower B.
- R5: The abort-gap flag sampled with the inputs appears in `out_word[18]`.
- R6: The 19 payload bits `out_word[18:0]` are mapped in ascending order onto codeword positions 1..24 that are not powers of two (3, 5, 6, 7, 9, ...). Check bit k is the XOR of the payload bits whose position has bit k set, and it is placed in `out_word[19+k]`.
- R7: A table write is taken only when `lut_we` is high, `in_valid` is low and no accepted sample is still in the first two stages. A write at any other time is dropped and leaves the table unchanged.
- R8: After reset `out_valid` is 0 and `out_word` is 0. `out_word` holds its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Depth energies and abort flag valid this cycle |
| twr_a_d0 | input | 16 | Tower A, first depth linear energy |
| twr_a_d1 | input | 16 | Tower A, second depth linear energy |
| twr_b_d0 | input | 16 | Tower B, first depth linear energy |
| twr_b_d1 | input | 16 | Tower B, second depth linear energy |
| abort_gap | input | 1 | Abort-gap flag for this crossing |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | 8 | Table write address |
| lut_data | input | 8 | Table write data |
| out_valid | output | 1 | Output word valid |
| out_word | output | 24 | Packed primitive word with check bits |

## Verification
A corrupted table entry or a bad clamp shows up as a wrong energy field in the very word that used that index, three cycles after the sample. The sweeps visit every index, including the clamp at 255 and the largest inputs. A pipeline stage that slips its valid bit shows up at once as a missing or extra `out_valid`, or as an output word changing while it should hold. A fault in the check-bit tree gives a nonzero syndrome on the affected word. A write that slips past the idle guard surfaces when a later lookup of that address returns the new value instead of the old one.

// File: rtl/tpe_pkg.sv
// Package: shared constants and the check-bit function for the primitive word.
// Assumes the fixed 24-bit word: 19 payload bits followed by 5 check bits.
package tpe_pkg;

    localparam int PAYLOAD_W = 19;
    localparam int CHECK_W   = 5;
    localparam int WORD_W    = PAYLOAD_W + CHECK_W;
    localparam int CODE_W    = 8;
    localparam int N_TOWERS  = 2;

    // Computes the check bits: payload is spread over the non-power-of-two codeword positions.
    function automatic logic [CHECK_W-1:0] ham_check(input logic [PAYLOAD_W-1:0] pay);
        logic [CHECK_W-1:0] chk;
        int                 di;
        chk = '0;
        di  = 0;
        for (int pos = 1; pos <= WORD_W; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                for (int k = 0; k < CHECK_W; k++) begin
                    if (((pos >> k) & 1) != 0) begin
                        chk[k] = chk[k] ^ pay[di];
                    end
                end
                di++;
            end
        end
        return chk;
    endfunction

endpackage

// File: rtl/tpe_tower.sv
// Module: first stage for one tower.
// Adds the two depth energies, clamps the sum to the table index range and tests
// the unclamped sum against the minimum-ionizing window. Results are registered
// only when a valid sample arrives.
// Assumes E_W >= IDX_W.
module tpe_tower #(
    parameter int E_W    = 16,
    parameter int IDX_W  = 8,
    parameter int MIP_LO = 6,
    parameter int MIP_HI = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [E_W-1:0]   dep0,
    input  logic [E_W-1:0]   dep1,
    output logic [IDX_W-1:0] idx_q,
    output logic             muon_q
);

    localparam int           SUM_W   = E_W + 1;
    localparam logic [SUM_W-1:0] IDX_MAX = SUM_W'((1 << IDX_W) - 1);
    localparam logic [SUM_W-1:0] WIN_LO  = SUM_W'(MIP_LO);
    localparam logic [SUM_W-1:0] WIN_HI  = SUM_W'(MIP_HI);

    logic [SUM_W-1:0] sum;
    logic [IDX_W-1:0] idx_c;
    logic             muon_c;

    // Full-width depth sum, clamp to the index range and window test.
    always_comb begin
        sum    = {1'b0, dep0} + {1'b0, dep1};
        idx_c  = (sum > IDX_MAX) ? IDX_MAX[IDX_W-1:0] : sum[IDX_W-1:0];
        muon_c = (sum >= WIN_LO) && (sum <= WIN_HI);
    end

    // Stage-one register for the clamped index and the muon bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            muon_q <= 1'b0;
        end else if (valid_in) begin
            idx_q  <= idx_c;
            muon_q <= muon_c;
        end
    end

endmodule

// File: rtl/tpe_lut.sv
// Module: energy compression table with one write port and NRD registered read ports.
// Assumes the caller guards writes so that no read of the same cycle depends on them.
// The contents are not reset; they must be loaded before use.
module tpe_lut #(
    parameter int AW  = 8,
    parameter int DW  = 8,
    parameter int NRD = 2
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Table write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            // Registered read for port r.
            always_ff @(posedge clk) begin
                rdata[r] <= mem[raddr[r]];
            end
        end
    endgenerate

endmodule

// File: rtl/tpe_pack.sv
// Module: output stage.
// Packs the tower codes, muon bits and abort flag, appends the check bits and
// registers the word. The word holds while no valid sample is present.
// Assumes exactly two towers in the fixed 24-bit layout.
module tpe_pack
    import tpe_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           valid_in,
    input  logic [N_TOWERS-1:0][CODE_W-1:0] code,
    input  logic [N_TOWERS-1:0]            muon,
    input  logic                           abort_in,
    output logic                           valid_q,
    output logic [WORD_W-1:0]              word_q
);

    logic [PAYLOAD_W-1:0] payload;

    // Payload layout: tower A low, tower B next, abort flag on top.
    always_comb begin
        payload = {abort_in, muon[1], code[1], muon[0], code[0]};
    end

    // Output register: strobe every cycle, word only on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            valid_q <= valid_in;
            if (valid_in) begin
                word_q <= {ham_check(payload), payload};
            end
        end
    end

endmodule

// File: rtl/tpe_encoder.sv
// Module: top of the trigger primitive encoder.
// Three-stage pipeline:
//   stage 1 sums and clamps each tower;
//   stage 2 reads the table;
//   stage 3 packs the word and adds the check bits.
// Assumes a sample may arrive on every clock. Table writes are gated off while
// samples are in stage 1 or 2.
module tpe_encoder
    import tpe_pkg::*;
#(
    parameter int E_W    = 16,
    parameter int IDX_W  = 8,
    parameter int MIP_LO = 6,
    parameter int MIP_HI = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [E_W-1:0]     twr_a_d0,
    input  logic [E_W-1:0]     twr_a_d1,
    input  logic [E_W-1:0]     twr_b_d0,
    input  logic [E_W-1:0]     twr_b_d1,
    input  logic               abort_gap,
    input  logic               lut_we,
    input  logic [IDX_W-1:0]   lut_addr,
    input  logic [CODE_W-1:0]  lut_data,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_word
);

    logic [N_TOWERS-1:0][E_W-1:0]    dep0;
    logic [N_TOWERS-1:0][E_W-1:0]    dep1;
    logic [N_TOWERS-1:0][IDX_W-1:0]  idx1;
    logic [N_TOWERS-1:0]             muon1;
    logic [N_TOWERS-1:0][CODE_W-1:0] code2;
    logic [N_TOWERS-1:0]             muon2;
    logic                            v1;
    logic                            v2;
    logic                            abort1;
    logic                            abort2;
    logic                            wr_ok;

    // Gather the tower inputs into arrays.
    always_comb begin
        dep0[0] = twr_a_d0;
        dep1[0] = twr_a_d1;
        dep0[1] = twr_b_d0;
        dep1[1] = twr_b_d1;
    end

    generate
        for (genvar t = 0; t < N_TOWERS; t++) begin : g_twr
            tpe_tower #(
                .E_W    (E_W),
                .IDX_W  (IDX_W),
                .MIP_LO (MIP_LO),
                .MIP_HI (MIP_HI)
            ) u_twr (
                .clk      (clk),
                .rst_n    (rst_n),
                .valid_in (in_valid),
                .dep0     (dep0[t]),
                .dep1     (dep1[t]),
                .idx_q    (idx1[t]),
                .muon_q   (muon1[t])
            );
        end
    endgenerate

    // Valid and abort flag through stages 1 and 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1     <= 1'b0;
            v2     <= 1'b0;
            abort1 <= 1'b0;
            abort2 <= 1'b0;
            muon2  <= '0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            if (in_valid) begin
                abort1 <= abort_gap;
            end
            if (v1) begin
                abort2 <= abort1;
                muon2  <= muon1;
            end
        end
    end

    // Table writes only while no sample is entering or inside stages 1 and 2.
    always_comb begin
        wr_ok = lut_we && !in_valid && !v1 && !v2;
    end

    tpe_lut #(
        .AW  (IDX_W),
        .DW  (CODE_W),
        .NRD (N_TOWERS)
    ) u_lut (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (lut_addr),
        .wdata (lut_data),
        .raddr (idx1),
        .rdata (code2)
    );

    tpe_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_in (v2),
        .code     (code2),
        .muon     (muon2),
        .abort_in (abort2),
        .valid_q  (out_valid),
        .word_q   (out_word)
    );

endmodule

// File: rtl/tpe_encoder_chk.sv
// Module: property checker bound to the encoder top; observes ports only.
module tpe_encoder_chk #(
    parameter int E_W    = 16,
    parameter int MIP_LO = 6,
    parameter int MIP_HI = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [E_W-1:0] twr_a_d0,
    input logic [E_W-1:0] twr_a_d1,
    input logic [E_W-1:0] twr_b_d0,
    input logic [E_W-1:0] twr_b_d1,
    input logic           abort_gap,
    input logic           out_valid,
    input logic [23:0]    out_word
);

    logic [E_W:0] sum_a;
    logic [E_W:0] sum_b;
    logic         win_a;
    logic         win_b;
    logic [4:0]   syn;

    // Window flags from the input ports, and the syndrome of the output word.
    always_comb begin
        sum_a = {1'b0, twr_a_d0} + {1'b0, twr_a_d1};
        sum_b = {1'b0, twr_b_d0} + {1'b0, twr_b_d1};
        win_a = (sum_a >= (E_W+1)'(MIP_LO)) && (sum_a <= (E_W+1)'(MIP_HI));
        win_b = (sum_b >= (E_W+1)'(MIP_LO)) && (sum_b <= (E_W+1)'(MIP_HI));
        syn   = '0;
        for (int k = 0; k < 5; k++) begin
            if (out_word[19+k]) syn = syn ^ 5'(1 << k);
        end
        begin
            int di;
            di = 0;
            for (int pos = 1; pos <= 24; pos++) begin
                if ((pos & (pos - 1)) != 0) begin
                    if (out_word[di]) syn = syn ^ pos[4:0];
                    di++;
                end
            end
        end
    end

    // R1
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R1
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // R4
    muon_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 (out_word[8] == $past(win_a, 3)));

    // R4
    muon_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 (out_word[17] == $past(win_b, 3)));

    // R5
    abort_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 (out_word[18] == $past(abort_gap, 3)));

    // R6
    syndrome_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (syn == 5'd0));

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_word));

endmodule

bind tpe_encoder tpe_encoder_chk #(
    .E_W    (E_W),
    .MIP_LO (MIP_LO),
    .MIP_HI (MIP_HI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .twr_a_d0  (twr_a_d0),
    .twr_a_d1  (twr_a_d1),
    .twr_b_d0  (twr_b_d0),
    .twr_b_d1  (twr_b_d1),
    .abort_gap (abort_gap),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/tpe_encoder_tb.sv
module tpe_encoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
    logic        abort_gap = 1'b0;
    logic        lut_we = 1'b0;
    logic [7:0]  lut_addr = '0;
    logic [7:0]  lut_data = '0;
    logic        out_valid;
    logic [23:0] out_word;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0]  lut_m [256];
    logic        pv [3];
    logic [23:0] pw [3];
    string       ptag [3];
    logic [23:0] last_word;

    always #10 clk = ~clk;

    tpe_encoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .twr_a_d0  (a0),
        .twr_a_d1  (a1),
        .twr_b_d0  (b0),
        .twr_b_d1  (b1),
        .abort_gap (abort_gap),
        .lut_we    (lut_we),
        .lut_addr  (lut_addr),
        .lut_data  (lut_data),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected word per R2..R6, built from the bench table model.
    function automatic logic [23:0] model(input logic [15:0] x0, x1, y0, y1, input logic ab);
        logic [16:0] sa, sb;
        logic [7:0]  ia, ib;
        logic        ma, mb;
        logic [18:0] pay;
        logic [24:0] cw;
        logic [4:0]  c;
        int          di;
        sa = 17'(x0) + 17'(x1);
        sb = 17'(y0) + 17'(y1);
        ia = (sa > 255) ? 8'd255 : sa[7:0];
        ib = (sb > 255) ? 8'd255 : sb[7:0];
        ma = (sa >= 6) && (sa <= 10);
        mb = (sb >= 6) && (sb <= 10);
        pay = {ab, mb, lut_m[ib], ma, lut_m[ia]};
        cw = '0;
        di = 0;
        for (int p = 3; p <= 24; p++) begin
            if (p != 4 && p != 8 && p != 16) begin
                cw[p] = pay[di];
                di++;
            end
        end
        for (int k = 0; k < 5; k++) begin
            c[k] = 1'b0;
            for (int p = 1; p <= 24; p++)
                if (p[k]) c[k] = c[k] ^ cw[p];
        end
        return {c, pay};
    endfunction

    // Syndrome of a received word: XOR of the positions of all set bits.
    function automatic logic [4:0] syndrome(input logic [23:0] w);
        logic [4:0] s;
        int di;
        s = '0;
        di = 0;
        for (int k = 0; k < 5; k++) if (w[19+k]) s = s ^ 5'(1 << k);
        for (int p = 1; p <= 24; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
                if (w[di]) s = s ^ 5'(p);
                di++;
            end
        end
        return s;
    endfunction

    task automatic step(input logic v, input logic [15:0] x0, x1, y0, y1, input logic ab,
                        input logic we, input logic [7:0] wa, input logic [7:0] wd, input string tag);
        logic busy;
        @(negedge clk);
        if (pv[2]) begin
            chk(out_valid === 1'b1, {"R1 valid ", ptag[2]}, {23'd0, out_valid}, 24'd1);
            chk(out_word === pw[2], ptag[2], out_word, pw[2]);
            chk(syndrome(out_word) == 5'd0, "R6 syndrome", {19'd0, syndrome(out_word)}, 24'd0);
            last_word = pw[2];
        end else begin
            chk(out_valid === 1'b0, "R1 idle", {23'd0, out_valid}, 24'd0);
            chk(out_word === last_word, "R8 hold", out_word, last_word);
        end
        pv[2] = pv[1]; pw[2] = pw[1]; ptag[2] = ptag[1];
        pv[1] = pv[0]; pw[1] = pw[0]; ptag[1] = ptag[0];
        busy = v | pv[1] | pv[2];
        if (we && !busy) lut_m[wa] = wd;
        pv[0] = v;
        pw[0] = model(x0, x1, y0, y1, ab);
        ptag[0] = tag;
        in_valid = v; a0 = x0; a1 = x1; b0 = y0; b1 = y1; abort_gap = ab;
        lut_we = we; lut_addr = wa; lut_data = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    endtask

    initial begin
        #(20 * 200000);
        $display("FAIL watchdog expired");
        failures++;
        checks++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin pv[i] = 0; pw[i] = '0; ptag[i] = ""; end
        for (int i = 0; i < 256; i++) lut_m[i] = 'x;
        last_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 reset valid", {23'd0, out_valid}, 24'd0);
        chk(out_word === 24'd0, "R8 reset word", out_word, 24'd0);
        rst_n = 1'b1;
        // Load the whole table (R7 idle writes).
        for (int i = 0; i < 256; i++) step(0, 0, 0, 0, 0, 0, 1, 8'(i), 8'((i * 37 + 11) & 255), "R7");
        // Sweep every index and beyond the clamp, with gaps (R2 R3 R4 R5 R6).
        for (int i = 0; i < 320; i++) begin
            logic [15:0] sa, sb;
            sa = 16'(i);
            sb = 16'(319 - i);
            step((i % 5) != 4, sa / 3, sa - sa / 3, 16'(i % 7), sb - 16'(i % 7) + ((sb < 16'(i % 7)) ? 16'(i % 7) : 16'd0),
                 i[0], 0, 0, 0, "R2 R3 R4 R5 sweep");
        end
        // Window edges back-to-back (R4).
        for (int s = 4; s <= 12; s++)
            step(1, 16'(s), 0, 0, 16'(16 - s), s[1], 0, 0, 0, "R4 window");
        // Clamp corners: no wrap (R2).
        step(1, 16'hFFFF, 16'hFFFF, 16'h8000, 16'h8000, 1, 0, 0, 0, "R2 clamp max");
        step(1, 16'd255, 16'd0, 16'd128, 16'd128, 0, 0, 0, 0, "R2 clamp edge");
        step(1, 16'hFFFF, 16'd1, 16'd3, 16'd3, 1, 0, 0, 0, "R2 wrap");
        // Writes while busy are dropped (R7).
        step(1, 16'd5, 0, 16'd6, 0, 0, 1, 8'd5, 8'hA5, "R7 write during valid");
        step(0, 0, 0, 0, 0, 0, 1, 8'd6, 8'h5A, "R7 write while in flight");
        step(0, 0, 0, 0, 0, 0, 1, 8'd5, 8'h3C, "R7 write while in flight");
        idle(2);
        step(0, 0, 0, 0, 0, 0, 1, 8'd6, 8'hC3, "R7 idle write");
        step(1, 16'd2, 16'd3, 16'd6, 16'd0, 0, 0, 0, 0, "R7 R3 lookup after writes");
        step(1, 16'd255, 0, 16'd0, 0, 1, 0, 0, 0, "R3 top index");
        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done = 1;
        $finish;
    end

endmodule